// File: doc/BRIEF.md
# Vectored Interrupt Controller with Hardware Flag Clearing

This block arbitrates interrupt requests for a small 8-bit processor core. Eighteen sources, numbered 0 to 17, each own a pending flag and an enable bit at the processor level. Eight of them also pass through a peripheral stage: a sticky peripheral flag and a peripheral mask must both be set before the processor-level flag can rise. Among pending sources whose enable bit is set, and only while the global enable is set, the lowest number wins. The controller presents a request, the winning index and a vector address equal to eight times the index plus three.

When the core takes the request with an acknowledge pulse, the controller clears the winning flag in hardware, but only for the sources that clear themselves (0, 1, 2, 3, 9, 10, 11, 12). Every other flag waits for software. The request output stays low from acknowledge until the core pulses return. Sources 6, 13 and 15 are level-type. While their peripheral flag and mask are both set, the processor flag keeps setting, so software must clear the peripheral flag first. Every other source is edge-type: a rising edge latches a sticky flag, and a held or removed input does not raise it again.

Software reaches the flags, enables, global enable and peripheral stage through a small write-strobe register port with a combinational read path.

Top module: `vic_top`

## Requirements
- R1: Request index is 0..17 and the vector is 8·index+3 (03h for source 0, 8Bh for source 17); with no request, index reads 0 and vector 03h.
- R2: With several enabled pending flags, the lowest-numbered source is reported.
- R3: A source raises the request only while the global enable (address 3, bit 0) and its own enable bit (address 2) are both set.
- R4: An acknowledge while the request is high clears the winning flag only for sources 0, 1, 2, 3, 9, 10, 11 and 12; other flags stay set.
- R5: For edge-type sources, a rising edge of the input (or, with a peripheral stage, of peripheral flag AND mask) sets a sticky flag; a held or removed input does not set it again after a clear.
- R6: For sources 6, 9, 10, 11, 12, 13, 15 and 16, an input cycle sets a sticky peripheral flag (read and write-1-clear at address 5); the processor flag is set by hardware only when that flag and the peripheral mask (address 4) are both set.
- R7: For sources 6, 13 and 15, the processor flag sets again in every cycle in which peripheral flag AND mask is set, even right after a software clear.
- R8: A hardware set of a flag in the same cycle as a software or acknowledge clear of that flag leaves it set; an input cycle likewise beats a software clear of the peripheral flag.
- R9: After an accepted acknowledge the request stays low until a return pulse; return wins over a simultaneous acknowledge.
- R10: Register port: address 0 write-1-sets flags, address 1 write-1-clears flags (both read the flags), address 2 enables, address 3 global enable, address 4 peripheral mask, address 5 peripheral flags; other addresses read 0; everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 18 | Per-source event inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data (combinational) |
| irq_req | output | 1 | Request to the core |
| irq_idx | output | 5 | Winning source index |
| irq_vec | output | 8 | Vector address of the winner |
| irq_ack | input | 1 | Core takes the request |
| irq_ret | input | 1 | Core returns from the handler |

## Verification
The hardest states to reach are the same-cycle collisions: a hardware set meeting a software clear, and a level source asserting again in the very cycle its flag is cleared. Both depend on a cycle-exact alignment of an input edge with a register write. Directed sequences line up an input pulse with a write-1-clear strobe in one cycle, and hold a peripheral flag under its mask while the processor flag is cleared. A long random phase then mixes sparse events, writes to every address, acknowledges and returns, all against a behavioural model compared on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC = 18;
  localparam int IDXW = $clog2(NSRC);
  localparam int VECW = 8;

  localparam logic [NSRC-1:0] SELFCLR_DEF = 18'h01E0F;
  localparam logic [NSRC-1:0] PSTAGE_DEF  = 18'h1BE40;
  localparam logic [NSRC-1:0] LEVEL_DEF   = 18'h0A040;

  typedef enum logic [2:0] {
    RA_FLAG_SET = 3'd0,
    RA_FLAG_CLR = 3'd1,
    RA_ENABLE   = 3'd2,
    RA_GLOBAL   = 3'd3,
    RA_PMASK    = 3'd4,
    RA_PFLAG    = 3'd5
  } reg_addr_e;

  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VECW'((int'(idx) << 3) + 3);
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
  parameter bit HAS_P  = 1'b0,
  parameter bit IS_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic pmask,
  input  logic pclr,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack_clr,
  output logic flag,
  output logic pflag,
  output logic hw_set
);
  logic prev_q;
  logic cond;
  logic pflag_d;

  assign pflag_d = HAS_P ? (evt | (pflag & ~pclr)) : 1'b0;
  assign cond    = HAS_P ? (pflag & pmask) : evt;
  assign hw_set  = IS_LVL ? cond : (cond & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      pflag  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      flag   <= hw_set | sw_set | (flag & ~sw_clr & ~ack_clr);
      pflag  <= pflag_d;
      prev_q <= cond;
    end
  end

  // R8: hardware set is never lost to a clear in the same cycle
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);

  // R5: a set flag only falls through an explicit clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !sw_clr && !ack_clr |=> flag);

  generate
    if (HAS_P) begin : g_pchk
      // R6: hardware raise needs peripheral flag and mask together
      p_pgate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) && !$past(sw_set) |-> $past(pflag && pmask));
    end
  endgenerate
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] PSTAGE = N'(PSTAGE_DEF)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [N-1:0] reg_wdata,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] pflags,
  output logic [N-1:0] en,
  output logic         glob,
  output logic [N-1:0] pmask,
  output logic [N-1:0] sw_set,
  output logic [N-1:0] sw_clr,
  output logic [N-1:0] pclr,
  output logic [N-1:0] reg_rdata
);
  logic wr_en, wr_glob, wr_pmask;

  assign wr_en    = reg_wr && (reg_addr == RA_ENABLE);
  assign wr_glob  = reg_wr && (reg_addr == RA_GLOBAL);
  assign wr_pmask = reg_wr && (reg_addr == RA_PMASK);
  assign sw_set   = (reg_wr && reg_addr == RA_FLAG_SET) ? reg_wdata : '0;
  assign sw_clr   = (reg_wr && reg_addr == RA_FLAG_CLR) ? reg_wdata : '0;
  assign pclr     = (reg_wr && reg_addr == RA_PFLAG)    ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      glob  <= 1'b0;
      pmask <= '0;
    end else begin
      if (wr_en)    en    <= reg_wdata;
      if (wr_glob)  glob  <= reg_wdata[0];
      if (wr_pmask) pmask <= reg_wdata & PSTAGE;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_FLAG_SET, RA_FLAG_CLR: reg_rdata = flags;
      RA_ENABLE:                reg_rdata = en;
      RA_GLOBAL:                reg_rdata = {{(N-1){1'b0}}, glob};
      RA_PMASK:                 reg_rdata = pmask;
      RA_PFLAG:                 reg_rdata = pflags;
      default:                  reg_rdata = '0;
    endcase
  end

  // R10: peripheral mask only holds bits of sources with a peripheral stage
  p_pmask_impl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pmask & ~PSTAGE) == '0);
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int N = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic          glob,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] live;

  assign live = glob ? (pend & en) : '0;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R3: a winner always has global and own enable set
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> glob && en[idx] && pend[idx]);
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] SELFCLR = N'(SELFCLR_DEF),
  parameter logic [N-1:0] PSTAGE  = N'(PSTAGE_DEF),
  parameter logic [N-1:0] LEVEL   = N'(LEVEL_DEF),
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_evt,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic          irq_req,
  output logic [IW-1:0] irq_idx,
  output logic [VECW-1:0] irq_vec,
  input  logic          irq_ack,
  input  logic          irq_ret
);
  logic [N-1:0] flags, pflags, hw_set, ack_clr;
  logic [N-1:0] en, pmask, sw_set, sw_clr, pclr;
  logic         glob, any, in_svc, ack_fire;
  logic [IW-1:0] win_idx;

  vic_regs #(.N(N), .PSTAGE(PSTAGE)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .flags(flags), .pflags(pflags), .en(en),
    .glob(glob), .pmask(pmask), .sw_set(sw_set), .sw_clr(sw_clr),
    .pclr(pclr), .reg_rdata(reg_rdata)
  );

  assign ack_fire = irq_ack && irq_req;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      assign ack_clr[i] = ack_fire && (win_idx == IW'(i)) && SELFCLR[i];
      vic_src_cell #(.HAS_P(PSTAGE[i]), .IS_LVL(LEVEL[i])) u_cell (
        .clk(clk), .rst_n(rst_n), .evt(src_evt[i]), .pmask(pmask[i]),
        .pclr(pclr[i]), .sw_set(sw_set[i]), .sw_clr(sw_clr[i]),
        .ack_clr(ack_clr[i]), .flag(flags[i]), .pflag(pflags[i]),
        .hw_set(hw_set[i])
      );
    end
  endgenerate

  vic_prio #(.N(N)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(flags), .en(en), .glob(glob),
    .any(any), .idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_svc <= 1'b0;
    else if (irq_ret)  in_svc <= 1'b0;
    else if (ack_fire) in_svc <= 1'b1;
  end

  assign irq_req = any && !in_svc;
  assign irq_idx = win_idx;
  assign irq_vec = vec_of(win_idx);

  // R9: an accepted acknowledge silences the request next cycle
  p_quiet_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && !irq_ret |=> !irq_req);

  // R1: vector low bits and index range
  p_vec_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3) && (int'(irq_idx) < N));

  // R4: at most one flag is cleared by an acknowledge
  p_one_ack_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));
endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/10ps
module test_vic_top;
  localparam int N = 18;
  localparam logic [N-1:0] AC = 18'h01E0F;
  localparam logic [N-1:0] PS = 18'h1BE40;
  localparam logic [N-1:0] LV = 18'h0A040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic irq_req;
  logic [4:0] irq_idx;
  logic [7:0] irq_vec;
  logic irq_ack = 1'b0;
  logic irq_ret = 1'b0;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // behavioural model
  bit mflag[N], men[N], mpm[N], mpf[N], mprev[N];
  bit mglob, minsvc;

  function automatic int m_win();
    for (int i = 0; i < N; i++)
      if (mflag[i] && men[i] && mglob) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mflag[i] = 0; men[i] = 0; mpm[i] = 0; mpf[i] = 0; mprev[i] = 0;
      end
      mglob = 0; minsvc = 0;
    end else begin
      int w;
      bit req, cond, hw, s, c, a;
      bit nf[N], npf[N], npr[N];
      w = m_win();
      req = (w >= 0) && !minsvc;
      for (int i = 0; i < N; i++) begin
        cond = PS[i] ? (mpf[i] && mpm[i]) : src_evt[i];
        hw = LV[i] ? cond : (cond && !mprev[i]);
        s = reg_wr && reg_addr == 3'd0 && reg_wdata[i];
        c = reg_wr && reg_addr == 3'd1 && reg_wdata[i];
        a = irq_ack && req && (w == i) && AC[i];
        nf[i] = hw || s || (mflag[i] && !c && !a);
        npf[i] = PS[i] && (src_evt[i] || (mpf[i] && !(reg_wr && reg_addr == 3'd5 && reg_wdata[i])));
        npr[i] = cond;
      end
      for (int i = 0; i < N; i++) begin
        mflag[i] = nf[i]; mpf[i] = npf[i]; mprev[i] = npr[i];
        if (reg_wr && reg_addr == 3'd2) men[i] = reg_wdata[i];
        if (reg_wr && reg_addr == 3'd4) mpm[i] = reg_wdata[i] && PS[i];
      end
      if (reg_wr && reg_addr == 3'd3) mglob = reg_wdata[0];
      if (irq_ret) minsvc = 0;
      else if (irq_ack && req) minsvc = 1;
    end
  end

  function automatic int m_rdata(input logic [2:0] ad);
    int v = 0;
    for (int i = 0; i < N; i++) begin
      case (ad)
        3'd0, 3'd1: if (mflag[i]) v |= (1 << i);
        3'd2: if (men[i]) v |= (1 << i);
        3'd4: if (mpm[i]) v |= (1 << i);
        3'd5: if (mpf[i]) v |= (1 << i);
        default: ;
      endcase
    end
    if (ad == 3'd3) v = mglob;
    return v;
  endfunction

  // per-clock comparison
  always @(negedge clk) begin
    #0.5;
    if (rst_n && !done) begin
      int w;
      int ei;
      w = m_win();
      ei = (w < 0) ? 0 : w;
      chk("R3/R9 req", int'(irq_req), int'((w >= 0) && !minsvc));
      chk("R2 idx", int'(irq_idx), ei);
      chk("R1 vec", int'(irq_vec), ei * 8 + 3);
      chk("R10 rdata", int'(reg_rdata), m_rdata(reg_addr));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic peek(input logic [2:0] ad, output logic [N-1:0] v);
    reg_addr = ad;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic pulse(input int s);
    src_evt[s] = 1'b1;
    tick();
    src_evt[s] = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) tick();
    chk("R10 reset req", int'(irq_req), 0);
    peek(3'd0, v); chk("R10 reset flags", int'(v), 0);
    peek(3'd2, v); chk("R10 reset enables", int'(v), 0);
    rst_n = 1'b1;
    tick();
    wr(3'd2, '1);
    wr(3'd3, 18'd1);

    pulse(17);
    chk("R1 req src17", int'(irq_req), 1);
    chk("R1 idx src17", int'(irq_idx), 17);
    chk("R1 vec src17", int'(irq_vec), 'h8B);
    pulse(0);
    chk("R2 idx lowest", int'(irq_idx), 0);
    chk("R1 vec src0", int'(irq_vec), 'h03);

    wr(3'd3, 18'd0);
    chk("R3 global off", int'(irq_req), 0);
    wr(3'd3, 18'd1);
    wr(3'd2, ~18'd1);
    chk("R3 own enable", int'(irq_idx), 17);
    wr(3'd2, '1);

    ack();
    chk("R9 req low after ack", int'(irq_req), 0);
    peek(3'd0, v); chk("R4 selfclear src0", int'(v[0]), 0);
    repeat (3) tick();
    chk("R9 still low", int'(irq_req), 0);
    ret();
    chk("R9 req back", int'(irq_req), 1);
    ack();
    peek(3'd0, v); chk("R4 src17 kept", int'(v[17]), 1);
    ret();
    wr(3'd1, 18'h20000);
    chk("R4 sw clear src17", int'(irq_req), 0);

    src_evt[5] = 1'b1;
    tick();
    peek(3'd0, v); chk("R5 edge set", int'(v[5]), 1);
    wr(3'd1, 18'h00020);
    tick();
    peek(3'd0, v); chk("R5 held no reraise", int'(v[5]), 0);
    src_evt[5] = 1'b0;
    tick();
    peek(3'd0, v); chk("R5 drop no reraise", int'(v[5]), 0);

    pulse(13);
    tick();
    peek(3'd5, v); chk("R6 pflag13 set", int'(v[13]), 1);
    peek(3'd0, v); chk("R6 masked no flag", int'(v[13]), 0);
    wr(3'd4, 18'h02000);
    tick();
    peek(3'd0, v); chk("R6 flag13 after mask", int'(v[13]), 1);
    wr(3'd1, 18'h02000);
    peek(3'd0, v); chk("R7 level reraise", int'(v[13]), 1);
    wr(3'd5, 18'h02000);
    wr(3'd1, 18'h02000);
    peek(3'd0, v); chk("R7 cleared after source", int'(v[13]), 0);

    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 18'h00010;
    src_evt[4] = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; src_evt[4] = 1'b0;
    peek(3'd0, v); chk("R8 hw beats clear", int'(v[4]), 1);
    wr(3'd1, 18'h00010);

    wr(3'd4, 18'h00200);
    pulse(9);
    tick();
    chk("R6 idx src9", int'(irq_idx), 9);
    ack();
    peek(3'd0, v); chk("R4 selfclear src9", int'(v[9]), 0);
    ret();
    peek(3'd0, v); chk("R5 periph edge no reraise", int'(v[9]), 0);
    wr(3'd5, 18'h00200);

    for (int k = 0; k < 3000; k++) begin
      src_evt = '0;
      for (int i = 0; i < N; i++) if ($urandom_range(0, 15) == 0) src_evt[i] = 1'b1;
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_addr = 3'($urandom_range(0, 6));
      reg_wdata = N'($urandom);
      if (reg_addr == 3'd3) reg_wdata[0] = ($urandom_range(0, 3) != 0);
      irq_ack = ($urandom_range(0, 3) == 0);
      irq_ret = ($urandom_range(0, 5) == 0);
      tick();
    end
    src_evt = '0; reg_wr = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule